// File: doc/BRIEF.md
# Decimating Time-Shared MAC FIR Filter

This block is a finite impulse response filter that reduces the sample rate by an integer factor K between 2 and 16. Every accepted input sample goes into a circular sample store, split over NMAC memory banks of N/NMAC entries each. Banks are filled one after another, and the write position wraps from the end of the last bank back to the start of the first. Only every K-th accepted sample starts a convolution. Each convolution is computed by NMAC multiply-accumulate lanes that work in parallel over N/NMAC clock cycles. The lane sums are then added into one full-precision signed result.

The input side is a signed sample bus qualified by a one-cycle strobe. The output side is a signed full-precision result with its own one-cycle strobe. Because only one output is computed per K inputs, a new sample may arrive as often as every ceil(N/(NMAC*K)) cycles. The sustainable input rate is therefore the clock rate times NMAC times K, divided by N. Samples that arrive while a convolution is running do not disturb it: each lane reads its bank from the oldest sample forward, so every read happens before the write that would replace that entry.

Top module: `mac_decim_fir`

## Requirements
- R1: Every output equals the sum over i = 0..N-1 of h[i]·x[n-i], computed at full precision. Here x[n] is the sample accepted with the strobe that triggers the output, and x[n-i] is the sample accepted i strobes earlier. Coefficient h[i] is the signed field COEF[i*CW +: CW].
- R2: After reset, no output is produced for the first N-1 accepted samples. The N-th accepted sample (index N-1, counting from 0) triggers the first output.
- R3: After the first output, exactly one output is triggered for every K accepted samples, on sample indices N-1+m·K. The input phase counter counts strobes modulo K starting from reset.
- R4: out_vld goes high exactly N/NMAC + 3 rising edges after the edge that samples the triggering in_vld.
- R5: out_vld is a one-cycle pulse. out_data keeps its value until the next pulse.
- R6: Reset is synchronous and active high. While it is held, out_vld and out_data are 0. Reset also returns the modulo-K phase and the fill count to zero, so the decimation phase after reset depends on nothing that came before it.
- R7: Strobes may arrive as close together as K·spacing = N/NMAC cycles, which makes convolutions run back to back. Samples written during a convolution do not change its result.
- R8: in_data has no effect in cycles where in_vld is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | One-cycle strobe: in_data holds a new sample |
| in_data | input | DW | Signed input sample (two's complement) |
| out_vld | output | 1 | One-cycle strobe: out_data holds a new result |
| out_data | output | OW | Signed full-precision filter result |

## Verification
The bench builds the filter with N = 12, NMAC = 3 (banks four entries deep), K = 2, and 16-bit data and coefficients. With these values the first firing phase, (N-1) mod K, is odd. When strobes are two cycles apart, consecutive convolutions overlap back to back, so the oldest window entries are replaced while they are still being read, including across a bank boundary. The small size allows an impulse response, full-scale streams at the highest rate, and gapped streams with junk data in the gaps, all compared against a sum computed in the bench. A reset in the middle of a stream shows that the decimation phase restarts from zero.

// File: rtl/mac_decim_fir_pkg.sv
package mac_decim_fir_pkg;
  // Address width for a count of n items; never below one bit.
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mac_decim_fir_ctrl.sv
module mac_decim_fir_ctrl #(
  parameter int TAPS  = 16,
  parameter int NMAC  = 4,
  parameter int DECIM = 3,
  localparam int DEPTH = TAPS / NMAC,
  localparam int AW    = mac_decim_fir_pkg::bits_for(DEPTH),
  localparam int BW    = mac_decim_fir_pkg::bits_for(NMAC),
  localparam int IW    = mac_decim_fir_pkg::bits_for(TAPS),
  localparam int PHW   = mac_decim_fir_pkg::bits_for(DECIM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  output logic           fire,
  output logic [BW-1:0]  wr_bank,
  output logic [AW-1:0]  wr_addr,
  output logic           busy,
  output logic           iss_first,
  output logic           iss_last,
  output logic [AW-1:0]  rd_addr,
  output logic [IW-1:0]  newest,
  output logic [PHW-1:0] phase,
  output logic           acc_done
);
  localparam int FIRE_PH = (TAPS - 1) % DECIM;

  logic [IW-1:0] seen;
  logic          primed;
  logic [AW-1:0] step;
  logic [2:0]    last_pipe;

  assign primed    = (seen == IW'(TAPS - 1));
  assign fire      = in_vld && primed && (phase == PHW'(FIRE_PH));
  assign iss_first = busy && (step == '0);
  assign iss_last  = busy && (step == AW'(DEPTH - 1));
  assign acc_done  = last_pipe[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      seen      <= '0;
      wr_bank   <= '0;
      wr_addr   <= '0;
      busy      <= 1'b0;
      step      <= '0;
      rd_addr   <= '0;
      newest    <= '0;
      last_pipe <= '0;
    end else begin
      if (in_vld) begin
        phase <= (phase == PHW'(DECIM - 1)) ? '0 : phase + 1'b1;
        if (!primed) seen <= seen + 1'b1;
        if (wr_addr == AW'(DEPTH - 1)) begin
          wr_addr <= '0;
          wr_bank <= (wr_bank == BW'(NMAC - 1)) ? '0 : wr_bank + 1'b1;
        end else begin
          wr_addr <= wr_addr + 1'b1;
        end
      end
      if (fire) begin
        // Start at the oldest entry of every bank: one past the newest write.
        busy    <= 1'b1;
        step    <= '0;
        rd_addr <= (wr_addr == AW'(DEPTH - 1)) ? '0 : wr_addr + 1'b1;
        newest  <= IW'(int'(wr_bank) * DEPTH + int'(wr_addr));
      end else if (busy) begin
        step    <= step + 1'b1;
        rd_addr <= (rd_addr == AW'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;
        if (step == AW'(DEPTH - 1)) busy <= 1'b0;
      end
      last_pipe <= {last_pipe[1:0], iss_last};
    end
  end
endmodule

// File: rtl/mac_decim_fir_lane.sv
module mac_decim_fir_lane #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 16,
  parameter int NMAC = 4,
  parameter int OW   = 40,
  parameter int LANE = 0,
  parameter logic [TAPS*CW-1:0] COEF = '0,
  localparam int DEPTH = TAPS / NMAC,
  localparam int AW    = mac_decim_fir_pkg::bits_for(DEPTH),
  localparam int IW    = mac_decim_fir_pkg::bits_for(TAPS),
  localparam int PW    = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic                 iss_v,
  input  logic                 iss_first,
  input  logic [AW-1:0]        rd_addr,
  input  logic [IW-1:0]        newest,
  output logic signed [OW-1:0] acc
);
  logic signed [DW-1:0] mem [DEPTH];
  logic signed [DW-1:0] rdata;
  logic signed [CW-1:0] coef_sel, coef_q;
  logic signed [PW-1:0] prod;
  logic signed [OW-1:0] prod_x;
  logic                 v1, f1, v2, f2;

  // Tap index of the slot being read: distance back from the newest sample.
  always_comb begin
    int slot, cidx;
    slot = LANE * DEPTH + int'(rd_addr);
    cidx = (int'(newest) >= slot) ? int'(newest) - slot
                                  : int'(newest) + TAPS - slot;
    coef_sel = COEF[cidx*CW +: CW];
  end

  assign prod_x = OW'(prod);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rdata  <= mem[rd_addr];
    coef_q <= coef_sel;
    prod   <= rdata * coef_q;
    if (v2) acc <= f2 ? prod_x : acc + prod_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      f1 <= 1'b0;
      v2 <= 1'b0;
      f2 <= 1'b0;
    end else begin
      v1 <= iss_v;
      f1 <= iss_first;
      v2 <= v1;
      f2 <= f1;
    end
  end
endmodule

// File: rtl/mac_decim_fir_sum.sv
module mac_decim_fir_sum #(
  parameter int NMAC = 4,
  parameter int OW   = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_done,
  input  logic [NMAC*OW-1:0]   acc_flat,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);
  logic signed [OW-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < NMAC; i++) total = total + acc_flat[i*OW +: OW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= acc_done;
      if (acc_done) out_data <= total;
    end
  end
endmodule

// File: rtl/mac_decim_fir.sv
module mac_decim_fir #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int TAPS  = 16,
  parameter int NMAC  = 4,
  parameter int DECIM = 3,
  parameter int OW    = 40,
  parameter logic [TAPS*CW-1:0] COEF = {TAPS{{{(CW-1){1'b0}}, 1'b1}}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);
  localparam int DEPTH = TAPS / NMAC;
  localparam int AW    = mac_decim_fir_pkg::bits_for(DEPTH);
  localparam int BW    = mac_decim_fir_pkg::bits_for(NMAC);
  localparam int IW    = mac_decim_fir_pkg::bits_for(TAPS);
  localparam int PHW   = mac_decim_fir_pkg::bits_for(DECIM);

  logic               fire, busy, iss_first, iss_last, acc_done;
  logic [BW-1:0]      wr_bank;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [IW-1:0]      newest;
  logic [PHW-1:0]     phase;
  logic [NMAC*OW-1:0] acc_flat;

  mac_decim_fir_ctrl #(.TAPS(TAPS), .NMAC(NMAC), .DECIM(DECIM)) u_ctrl (
    .clk(clk), .rst(rst), .in_vld(in_vld), .fire(fire),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .busy(busy),
    .iss_first(iss_first), .iss_last(iss_last), .rd_addr(rd_addr),
    .newest(newest), .phase(phase), .acc_done(acc_done)
  );

  for (genvar b = 0; b < NMAC; b++) begin : g_lane
    logic                 lane_we;
    logic signed [OW-1:0] lane_acc;
    assign lane_we = in_vld && (wr_bank == BW'(b));
    assign acc_flat[b*OW +: OW] = lane_acc;
    mac_decim_fir_lane #(
      .DW(DW), .CW(CW), .TAPS(TAPS), .NMAC(NMAC), .OW(OW),
      .LANE(b), .COEF(COEF)
    ) u_lane (
      .clk(clk), .rst(rst), .wr_en(lane_we), .wr_addr(wr_addr),
      .wr_data(in_data), .iss_v(busy), .iss_first(iss_first),
      .rd_addr(rd_addr), .newest(newest), .acc(lane_acc)
    );
  end

  mac_decim_fir_sum #(.NMAC(NMAC), .OW(OW)) u_sum (
    .clk(clk), .rst(rst), .acc_done(acc_done), .acc_flat(acc_flat),
    .out_vld(out_vld), .out_data(out_data)
  );
endmodule

// File: rtl/mac_decim_fir_chk.sv
module mac_decim_fir_chk #(
  parameter int TAPS  = 16,
  parameter int DECIM = 3,
  parameter int PHW   = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           in_vld,
  input logic           fire,
  input logic           busy,
  input logic           iss_last,
  input logic           out_vld,
  input logic [PHW-1:0] phase
);
  int   since_fire, total_in, pending;
  logic had_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fire <= 0;
      total_in   <= 0;
      pending    <= 0;
      had_fire   <= 1'b0;
    end else begin
      if (fire) begin
        since_fire <= 0;
        had_fire   <= 1'b1;
      end else if (in_vld) begin
        since_fire <= since_fire + 1;
      end
      if (in_vld && total_in < TAPS) total_in <= total_in + 1;
      pending <= pending + int'(fire) - int'(out_vld);
    end
  end

  a_r2_first_after_fill: assert property (@(posedge clk) disable iff (rst)
    (fire && !had_fire) |-> (total_in == TAPS - 1));

  a_r3_every_kth: assert property (@(posedge clk) disable iff (rst)
    (fire && had_fire) |-> (since_fire == DECIM - 1));

  a_r4_no_orphan_output: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (pending > 0));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  a_r6_reset_state: assert property (@(posedge clk)
    rst |=> (!out_vld && phase == '0));

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (fire && busy) |-> iss_last);
endmodule

bind mac_decim_fir mac_decim_fir_chk #(.TAPS(TAPS), .DECIM(DECIM), .PHW(PHW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .fire(fire), .busy(busy),
  .iss_last(iss_last), .out_vld(out_vld), .phase(phase)
);

// File: tb/test_mac_decim_fir.sv
`timescale 1ns/1ps
module test_mac_decim_fir;
  localparam int DW = 16, CW = 16, N = 12, M = 3, K = 2, OW = 40;
  localparam int D = N / M;
  localparam int LAT = D + 4;  // counter steps from drive point to visible strobe

  function automatic logic signed [15:0] hc(input int i);
    int v;
    v = ((i * 7919 + 1234) % 65536) - 32768;
    if (i == 5) v = -32768;
    return 16'(v);
  endfunction

  function automatic logic [N*CW-1:0] pack_coefs();
    logic [N*CW-1:0] v;
    for (int i = 0; i < N; i++) v[i*CW +: CW] = hc(i);
    return v;
  endfunction

  localparam logic [N*CW-1:0] COEFS = pack_coefs();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_vld;
  logic signed [OW-1:0] out_data;

  always #10 clk = ~clk;

  mac_decim_fir #(.DW(DW), .CW(CW), .TAPS(N), .NMAC(M), .DECIM(K), .OW(OW),
                  .COEF(COEFS)) i_mac_decim_fir (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, out_count = 0;
  longint hist[$];
  longint exp_v[$];
  int     exp_c[$];
  string  tag = "R1";
  logic   prev_vld = 1'b0;
  longint last_out = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Called at a negedge; drives one sample and returns sp cycles later.
  task automatic send(input longint v, input int sp);
    int idx;
    idx = hist.size();
    hist.push_back(v);
    if (idx >= N - 1 && ((idx - (N - 1)) % K) == 0) begin
      longint y = 0;
      for (int i = 0; i < N; i++) y += longint'(hc(i)) * hist[idx - i];
      exp_v.push_back(y);
      exp_c.push_back(cyc + LAT);
    end
    in_data = 16'(v);
    in_vld  = 1'b1;
    @(negedge clk);
    in_vld  = 1'b0;
    in_data = 16'(cyc * 40503) ^ 16'hA5C3;  // junk while strobe is low (R8)
    repeat (sp - 1) @(negedge clk);
  endtask

  task automatic drain(input string req);
    repeat (D + 10) @(negedge clk);
    chk(exp_v.size() == 0, req, exp_v.size(), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R6 out_vld in reset", out_vld, 0);
    chk(out_data == '0, "R6 out_data in reset", out_data, 0);
    hist.delete();
    exp_v.delete();
    exp_c.delete();
    rst = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_vld) begin
        out_count++;
        if (exp_v.size() == 0) begin
          chk(1'b0, "R3 unexpected output", out_data, 0);
        end else begin
          longint ev;
          int ec;
          ev = exp_v.pop_front();
          ec = exp_c.pop_front();
          chk(out_data == ev, tag, out_data, ev);
          chk(cyc == ec, "R4 latency", cyc, ec);
        end
        last_out = out_data;
      end else if (prev_vld) begin
        chk(out_data == last_out, "R5 hold", out_data, last_out);
      end
      prev_vld = out_vld;
    end else begin
      prev_vld = 1'b0;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();

    // Impulse: zeros fill the window, then one unit sample (R1, R2).
    tag = "R1 impulse";
    for (int i = 0; i < N - 1; i++) send(0, 3);
    repeat (D + 8) @(negedge clk);
    chk(out_count == 0, "R2 no output before full window", out_count, 0);
    send(1, 3);
    repeat (D + 8) @(negedge clk);
    chk(out_count == 1, "R2 first output on N-th sample", out_count, 1);
    for (int i = 0; i < 2 * N; i++) send(0, 3);
    drain("R3 impulse outputs all seen");

    // Full-scale stream at the highest rate: back-to-back convolutions (R7).
    tag = "R7 back-to-back";
    for (int i = 0; i < 40; i++) begin
      longint v;
      v = (i % 5 == 0) ? -32768 : (i % 7 == 0) ? 32767 : longint'(((i * 9973) % 65536) - 32768);
      send(v, 2);
    end
    drain("R7 stream outputs all seen");

    // Gapped stream, junk on the data bus between strobes (R8).
    tag = "R8 gapped";
    for (int i = 0; i < 30; i++) send(longint'(((i * 3571 + 77) % 60000) - 30000), 5);
    drain("R8 gapped outputs all seen");

    // Reset mid-stream with phase left nonzero, then check phase restart (R6, R3).
    for (int i = 0; i < 5; i++) send(longint'(i * 1000 - 2000), 3);
    do_reset();
    out_count = 0;
    tag = "R3 after reset";
    for (int i = 0; i < 20; i++) send(longint'(((i * 4099) % 50000) - 25000), 3);
    drain("R3 outputs after reset all seen");
    chk(out_count == 5, "R3 output count after reset", out_count, 5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule